// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits behind the command line of a memory-card host controller. Once a command has gone out, it watches the serial line for the card's answer. It counts card-clock strobes while it waits. When the start bit arrives, it shifts the answer into a capture register. Software then reads the captured answer as a sequence of 16-bit halfwords from a single read port.

The response kind is chosen per command:
- no answer at all;
- a short 48-bit answer, with or without a CRC7 check;
- a long 136-bit answer.

The block reports three things: that the command phase is finished, that the answer did not arrive within the programmed limit, and that a checked short answer failed its CRC.

A short answer is read as three halfwords a, b, c. The 32-bit payload is rebuilt as `a<<24 | b<<8 | c>>8`. A long answer is read as eight halfwords. Each consecutive pair forms one 32-bit word, with the first-read halfword as the high half.

Top module: `rsp_capture_fifo`

## Requirements
- R1: After reset, cmd_done_o, rsp_tmo_o and rsp_crc_err_o are 0, rd_data_o is 0, and the timeout limit register holds 8'hFF.
- R2: rsp_kind_i is sampled on cmd_start_i with code 0 = none, 1 = 48-bit checked, 2 = 136-bit, 3 = 48-bit unchecked. Kind 0 raises cmd_done_o one cycle after the start pulse and provides no read data.
- R3: For kinds 1 and 3, the frame is the 48 strobed bits, first bit = frame bit 47. Successive reads return frame[47:32], frame[31:16] and frame[15:0], so that a<<24 | b<<8 | c>>8 equals frame[39:8].
- R4: For kind 2, successive reads return the halfwords of frame[127:0], most significant first, eight in all. The eight leading frame bits are dropped.
- R5: For kind 1, a CRC7 (x^7+x^3+1) over frame bits 46..8 that differs from frame bits 7..1 sets rsp_crc_err_o together with cmd_done_o. A matching CRC leaves rsp_crc_err_o at 0.
- R6: Kinds 2 and 3 never set rsp_crc_err_o, whatever the CRC bits hold.
- R7: While waiting, each strobe with line_bit_i = 1 counts as an idle card cycle. When the count reaches the limit L (a limit of 0 acts as 1), rsp_tmo_o and cmd_done_o set and rd_data_o stays 0.
- R8: A cycle with tmo_wr_i high loads tmo_val_i into the limit register. The limit in force before any write is 255.
- R9: Each rd_en_i pulse advances the read pointer by one, saturating after eight reads. Reads past the captured length, or made before completion, return 0. A start pulse rewinds the pointer.
- R10: Cycles with line_vld_i low are ignored, whatever line_bit_i holds. The status flags hold until the next cmd_start_i, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Pulse: command issued, begin waiting for the answer |
| rsp_kind_i | input | 2 | Response kind code, sampled on cmd_start_i |
| line_bit_i | input | 1 | Serial bit from the command line |
| line_vld_i | input | 1 | Strobe: line_bit_i holds one card-clock bit |
| tmo_wr_i | input | 1 | Load the timeout limit register |
| tmo_val_i | input | TMO_W | New timeout limit, in card clock cycles |
| rd_en_i | input | 1 | Read strobe for the halfword port |
| rd_data_o | output | 16 | Halfword at the read pointer (show-ahead) |
| cmd_done_o | output | 1 | End of command response, or timeout |
| rsp_tmo_o | output | 1 | No start bit within the limit |
| rsp_crc_err_o | output | 1 | Checked short answer failed CRC7 |

## Verification
The properties assume that cmd_start_i is a single-cycle pulse and that the timeout limit is not rewritten while a response is pending. They also assume that reads are issued only between one start pulse and the next. The bench keeps to these rules by changing the limit only between commands and by reading only after cmd_done_o is high. Frames are built with a CRC computed in the bench and are strobed with gap cycles, and the line is driven low during those gaps. Timeout runs probe the cycle just before and the cycle exactly at the limit.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;

    localparam int HW_W        = 16;
    localparam int SHORT_LEN   = 48;
    localparam int LONG_LEN    = 136;
    localparam int STORE_W     = 128;
    localparam int SHORT_WORDS = SHORT_LEN / HW_W;
    localparam int LONG_WORDS  = STORE_W / HW_W;
    localparam int CRC_W       = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
    localparam int BITCNT_W    = $clog2(LONG_LEN);
    localparam int PTR_W       = $clog2(LONG_WORDS + 1);

    typedef enum logic [1:0] {
        RK_NONE      = 2'd0,
        RK_SHORT_CRC = 2'd1,
        RK_LONG      = 2'd2,
        RK_SHORT     = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_RECV,
        RX_DONE
    } rx_state_e;

    // One serial step of the CRC7 shift register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // Index of the final (stop) bit of a frame of this kind.
    function automatic logic [BITCNT_W-1:0] last_index(input rsp_kind_e k);
        return (k == RK_LONG) ? BITCNT_W'(LONG_LEN - 1) : BITCNT_W'(SHORT_LEN - 1);
    endfunction

    // Number of halfwords software may read for this kind.
    function automatic logic [PTR_W-1:0] word_count(input rsp_kind_e k);
        logic [PTR_W-1:0] n;
        case (k)
            RK_NONE: n = '0;
            RK_LONG: n = PTR_W'(LONG_WORDS);
            default: n = PTR_W'(SHORT_WORDS);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rsp_tmo_reg.sv
module rsp_tmo_reg #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [TMO_W-1:0] val_i,
    output logic [TMO_W-1:0] lim_o
);
    logic [TMO_W-1:0] lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (wr_i) lim_d = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lim_q <= '1;
        else        lim_q <= lim_d;
    end

    assign lim_o = lim_q;
endmodule

// File: rtl/rsp_rx_ctrl.sv
module rsp_rx_ctrl
    import rsp_cap_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  rsp_kind_e          kind_i,
    input  logic               bit_i,
    input  logic               vld_i,
    input  logic [TMO_W-1:0]   lim_i,
    output rsp_kind_e          kind_o,
    output logic [STORE_W-1:0] sh_o,
    output logic               done_o,
    output logic               tmo_o,
    output logic               crc_err_o
);
    typedef struct packed {
        rx_state_e            st;
        rsp_kind_e            kind;
        logic [BITCNT_W-1:0]  bcnt;
        logic [TMO_W-1:0]     idle;
        logic [CRC_W-1:0]     crc;
        logic [STORE_W-1:0]   sh;
        logic                 done;
        logic                 tmo;
        logic                 crc_err;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [TMO_W:0] idle_nx;

    always_comb begin
        d       = q;
        idle_nx = {1'b0, q.idle} + 1'b1;
        if (start_i) begin
            d.st      = (kind_i == RK_NONE) ? RX_DONE : RX_WAIT;
            d.kind    = kind_i;
            d.bcnt    = '0;
            d.idle    = '0;
            d.crc     = '0;
            d.sh      = '0;
            d.done    = (kind_i == RK_NONE);
            d.tmo     = 1'b0;
            d.crc_err = 1'b0;
        end else begin
            case (q.st)
                RX_WAIT: begin
                    if (vld_i) begin
                        if (!bit_i) begin
                            d.st   = RX_RECV;
                            d.bcnt = BITCNT_W'(1);
                            d.sh   = {q.sh[STORE_W-2:0], 1'b0};
                        end else begin
                            d.idle = idle_nx[TMO_W-1:0];
                            if (idle_nx >= {1'b0, lim_i}) begin
                                d.st   = RX_DONE;
                                d.done = 1'b1;
                                d.tmo  = 1'b1;
                            end
                        end
                    end
                end
                RX_RECV: begin
                    if (vld_i) begin
                        d.sh   = {q.sh[STORE_W-2:0], bit_i};
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == last_index(q.kind)) begin
                            d.st      = RX_DONE;
                            d.done    = 1'b1;
                            d.crc_err = (q.kind == RK_SHORT_CRC) && (q.crc != '0);
                        end else begin
                            d.crc = crc_step(q.crc, bit_i);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, kind: RK_NONE, bcnt: '0, idle: '0, crc: '0,
                   sh: '0, done: 1'b0, tmo: 1'b0, crc_err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign kind_o    = q.kind;
    assign sh_o      = q.sh;
    assign done_o    = q.done;
    assign tmo_o     = q.tmo;
    assign crc_err_o = q.crc_err;
endmodule

// File: rtl/rsp_rd_port.sv
module rsp_rd_port
    import rsp_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rd_i,
    input  rsp_kind_e          kind_i,
    input  logic               done_i,
    input  logic               tmo_i,
    input  logic [STORE_W-1:0] sh_i,
    output logic [HW_W-1:0]    data_o
);
    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic [HW_W-1:0]  long_hw  [LONG_WORDS];
    logic [HW_W-1:0]  short_hw [SHORT_WORDS];
    logic [HW_W-1:0]  sel;
    logic             avail;

    for (genvar g = 0; g < LONG_WORDS; g++) begin : g_long
        assign long_hw[g] = sh_i[STORE_W-1-HW_W*g -: HW_W];
    end

    for (genvar g = 0; g < SHORT_WORDS; g++) begin : g_short
        assign short_hw[g] = sh_i[SHORT_LEN-1-HW_W*g -: HW_W];
    end

    always_comb begin
        ptr_d = ptr_q;
        if (start_i)                                  ptr_d = '0;
        else if (rd_i && ptr_q < PTR_W'(LONG_WORDS))  ptr_d = ptr_q + 1'b1;
    end

    always_comb begin
        sel = '0;
        if (kind_i == RK_LONG) begin
            for (int k = 0; k < LONG_WORDS; k++)
                if (ptr_q == PTR_W'(k)) sel = long_hw[k];
        end else begin
            for (int k = 0; k < SHORT_WORDS; k++)
                if (ptr_q == PTR_W'(k)) sel = short_hw[k];
        end
        avail  = done_i && !tmo_i && (ptr_q < word_count(kind_i));
        data_o = avail ? sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/rsp_capture_fifo.sv
module rsp_capture_fifo
    import rsp_cap_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_i,
    input  logic [1:0]       rsp_kind_i,
    input  logic             line_bit_i,
    input  logic             line_vld_i,
    input  logic             tmo_wr_i,
    input  logic [TMO_W-1:0] tmo_val_i,
    input  logic             rd_en_i,
    output logic [15:0]      rd_data_o,
    output logic             cmd_done_o,
    output logic             rsp_tmo_o,
    output logic             rsp_crc_err_o
);
    logic [TMO_W-1:0]   lim;
    rsp_kind_e          kind_q;
    logic [STORE_W-1:0] sh;
    logic               done, tmo, crc_err;

    rsp_tmo_reg #(.TMO_W(TMO_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (tmo_wr_i),
        .val_i (tmo_val_i),
        .lim_o (lim)
    );

    rsp_rx_ctrl #(.TMO_W(TMO_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cmd_start_i),
        .kind_i    (rsp_kind_e'(rsp_kind_i)),
        .bit_i     (line_bit_i),
        .vld_i     (line_vld_i),
        .lim_i     (lim),
        .kind_o    (kind_q),
        .sh_o      (sh),
        .done_o    (done),
        .tmo_o     (tmo),
        .crc_err_o (crc_err)
    );

    rsp_rd_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cmd_start_i),
        .rd_i    (rd_en_i),
        .kind_i  (kind_q),
        .done_i  (done),
        .tmo_i   (tmo),
        .sh_i    (sh),
        .data_o  (rd_data_o)
    );

    assign cmd_done_o    = done;
    assign rsp_tmo_o     = tmo;
    assign rsp_crc_err_o = crc_err;
endmodule

// File: rtl/rsp_capture_fifo_chk.sv
module rsp_capture_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start_i,
    input logic [1:0]  rsp_kind_i,
    input logic [15:0] rd_data_o,
    input logic        cmd_done_o,
    input logic        rsp_tmo_o,
    input logic        rsp_crc_err_o
);
    // R7: a timeout always ends the command phase
    a_r7_tmo_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tmo_o |-> cmd_done_o);

    // R5: a CRC failure is only reported on a finished answer
    a_r5_crc_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_crc_err_o |-> cmd_done_o);

    // R5: a timed-out command never also reports a CRC failure
    a_r5_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_tmo_o && rsp_crc_err_o));

    // R2: no-answer commands finish at once with nothing to read
    a_r2_none_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_i && rsp_kind_i == 2'd0) |=> (cmd_done_o && rd_data_o == 16'h0));

    // R10: a start pulse clears the error flags
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_i |=> (!rsp_tmo_o && !rsp_crc_err_o));

    // R10: completion is sticky until the next start
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_o && !cmd_start_i) |=> cmd_done_o);

    // R9: read data only appears once the answer is complete
    a_r9_data_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o != 16'h0) |-> cmd_done_o);
endmodule

bind rsp_capture_fifo rsp_capture_fifo_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start_i   (cmd_start_i),
    .rsp_kind_i    (rsp_kind_i),
    .rd_data_o     (rd_data_o),
    .cmd_done_o    (cmd_done_o),
    .rsp_tmo_o     (rsp_tmo_o),
    .rsp_crc_err_o (rsp_crc_err_o)
);

// File: tb/rsp_capture_fifo_tb_top.sv
module rsp_capture_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start_i = 1'b0;
    logic [1:0]  rsp_kind_i = 2'd0;
    logic        line_bit_i = 1'b1;
    logic        line_vld_i = 1'b0;
    logic        tmo_wr_i = 1'b0;
    logic [7:0]  tmo_val_i = 8'd0;
    logic        rd_en_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        cmd_done_o, rsp_tmo_o, rsp_crc_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit live = 0;

    always #10 clk = ~clk;

    rsp_capture_fifo dut_i (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;            // 0 idle, 1 waiting, 2 receiving, 3 finished
    int m_kind = 0;
    int m_idle = 0;
    int m_lim = 255;
    int m_ptr = 0;
    bit m_done = 0, m_tmo = 0, m_crc = 0;
    bit m_bits[$];

    function automatic bit crc_bad(input bit b[$]);
        logic [6:0] c = 7'h0;
        logic [6:0] got;
        for (int i = 1; i <= 39; i++) begin
            logic fb = b[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        for (int i = 0; i < 7; i++) got[6-i] = b[40+i];
        return got != c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_kind = 0; m_idle = 0; m_lim = 255; m_ptr = 0;
            m_done = 0; m_tmo = 0; m_crc = 0; m_bits.delete();
        end else begin
            if (cmd_start_i) begin
                m_kind = int'(rsp_kind_i);
                m_st   = (m_kind == 0) ? 3 : 1;
                m_done = (m_kind == 0);
                m_tmo = 0; m_crc = 0; m_idle = 0; m_bits.delete();
                m_ptr = 0;
            end else begin
                if (m_st == 1 && line_vld_i) begin
                    if (!line_bit_i) begin
                        m_bits.push_back(1'b0);
                        m_st = 2;
                    end else begin
                        m_idle++;
                        if (m_idle >= m_lim) begin m_tmo = 1; m_done = 1; m_st = 3; end
                    end
                end else if (m_st == 2 && line_vld_i) begin
                    m_bits.push_back(line_bit_i);
                    if (m_bits.size() == ((m_kind == 2) ? 136 : 48)) begin
                        m_done = 1; m_st = 3;
                        if (m_kind == 1) m_crc = crc_bad(m_bits);
                    end
                end
                if (rd_en_i && m_ptr < 8) m_ptr++;
            end
            if (tmo_wr_i) m_lim = int'(tmo_val_i);
            live = 1;
        end
    end

    function automatic logic [15:0] m_word();
        int nw, base;
        logic [15:0] w = '0;
        if (m_st != 3 || m_tmo) return 16'h0;
        nw = (m_kind == 2) ? 8 : (m_kind == 0) ? 0 : 3;
        if (m_ptr >= nw) return 16'h0;
        base = (m_kind == 2) ? 8 + 16 * m_ptr : 16 * m_ptr;
        for (int j = 0; j < 16; j++) w[15-j] = m_bits[base+j];
        return w;
    endfunction

    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R2",  "cmd_done",    {31'd0, cmd_done_o},    {31'd0, m_done});
            chk("R7",  "rsp_tmo",     {31'd0, rsp_tmo_o},     {31'd0, m_tmo});
            chk("R5",  "rsp_crc_err", {31'd0, rsp_crc_err_o}, {31'd0, m_crc});
            chk("R9",  "rd_data",     {16'd0, rd_data_o},     {16'd0, m_word()});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic start_cmd(input logic [1:0] k);
        @(negedge clk); cmd_start_i = 1'b1; rsp_kind_i = k; line_vld_i = 1'b0;
        @(negedge clk); cmd_start_i = 1'b0;
    endtask

    task automatic strobe(input logic b);
        @(negedge clk); line_vld_i = 1'b1; line_bit_i = b;
    endtask

    task automatic gap();
        @(negedge clk); line_vld_i = 1'b0; line_bit_i = 1'b0;
    endtask

    task automatic send(input logic [135:0] f, input int len, input int pre);
        for (int i = 0; i < pre; i++) strobe(1'b1);
        for (int i = len - 1; i >= 0; i--) begin
            strobe(f[i]);
            if (i % 7 == 3) gap();
        end
        gap();
        gap();
    endtask

    task automatic rd_word(output logic [15:0] v);
        @(negedge clk); v = rd_data_o; rd_en_i = 1'b1;
        @(negedge clk); rd_en_i = 1'b0;
    endtask

    task automatic set_lim(input logic [7:0] v);
        @(negedge clk); tmo_wr_i = 1'b1; tmo_val_i = v;
        @(negedge clk); tmo_wr_i = 1'b0;
    endtask

    function automatic logic [47:0] short_frame(input logic [5:0] idx, input logic [31:0] arg, input bit corrupt);
        logic [39:0] msg = {2'b00, idx, arg};
        logic [6:0] c = 7'h0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = msg[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        if (corrupt) c[0] = ~c[0];
        return {msg, c, 1'b1};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0]  sf;
        logic [135:0] lf;
        logic [15:0]  w [8];
        logic [15:0]  v;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "done at reset", {31'd0, cmd_done_o}, 32'd0);
        chk("R1", "tmo at reset", {31'd0, rsp_tmo_o}, 32'd0);
        chk("R1", "data at reset", {16'd0, rd_data_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: default limit of 255 idle cycles
        start_cmd(2'd1);
        for (int i = 0; i < 254; i++) strobe(1'b1);
        gap(); gap();
        chk("R8", "no timeout at 254", {31'd0, rsp_tmo_o}, 32'd0);
        strobe(1'b1); gap(); gap();
        chk("R8", "timeout at 255", {31'd0, rsp_tmo_o}, 32'd1);

        // R2: no-answer kind
        start_cmd(2'd0);
        chk("R2", "none done", {31'd0, cmd_done_o}, 32'd1);
        rd_word(v);
        chk("R2", "none data", {16'd0, v}, 32'd0);

        // R3 / R5: checked short answer, good CRC
        set_lim(8'd20);
        sf = short_frame(6'h11, 32'hDEAD_BEEF, 1'b0);
        start_cmd(2'd1);
        // R10: invalid cycles carrying a low bit must not start reception
        for (int i = 0; i < 4; i++) gap();
        chk("R10", "gap ignored", {31'd0, cmd_done_o}, 32'd0);
        send({88'd0, sf}, 48, 3);
        chk("R5", "good crc", {31'd0, rsp_crc_err_o}, 32'd0);
        for (int k = 0; k < 5; k++) begin rd_word(v); w[k] = v; end
        chk("R3", "half a", {16'd0, w[0]}, {16'd0, sf[47:32]});
        chk("R3", "half c", {16'd0, w[2]}, {16'd0, sf[15:0]});
        chk("R3", "payload", ({16'd0, w[0]} << 24) | ({16'd0, w[1]} << 8) | ({16'd0, w[2]} >> 8), 32'hDEAD_BEEF);
        chk("R9", "beyond short", {16'd0, w[3] | w[4]}, 32'd0);

        // R5: checked short answer, corrupted CRC
        start_cmd(2'd1);
        send({88'd0, short_frame(6'h05, 32'h1234_5678, 1'b1)}, 48, 1);
        chk("R5", "bad crc", {30'd0, cmd_done_o, rsp_crc_err_o}, 32'd3);

        // R6: unchecked short answer, corrupted CRC
        start_cmd(2'd3);
        send({88'd0, short_frame(6'h2A, 32'h0BAD_F00D, 1'b1)}, 48, 0);
        chk("R6", "short no check", {30'd0, cmd_done_o, rsp_crc_err_o}, 32'd2);

        // R4 / R6: long answer
        lf = {2'b00, 6'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211};
        start_cmd(2'd2);
        send(lf, 136, 2);
        chk("R6", "long no check", {31'd0, rsp_crc_err_o}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            rd_word(v);
            chk("R4", "long half", {16'd0, v}, {16'd0, lf[127-16*k -: 16]});
        end
        rd_word(v);
        chk("R9", "beyond long", {16'd0, v}, 32'd0);

        // R9: start rewinds the read pointer
        start_cmd(2'd3);
        sf = short_frame(6'h01, 32'hCAFE_0001, 1'b0);
        send({88'd0, sf}, 48, 0);
        rd_word(v);
        chk("R9", "rewound", {16'd0, v}, {16'd0, sf[47:32]});

        // R7: programmed limit of 5
        set_lim(8'd5);
        start_cmd(2'd1);
        for (int i = 0; i < 4; i++) strobe(1'b1);
        gap();
        chk("R7", "no timeout at 4", {31'd0, rsp_tmo_o}, 32'd0);
        strobe(1'b1); gap(); gap();
        chk("R7", "timeout at 5", {30'd0, cmd_done_o, rsp_tmo_o}, 32'd3);
        rd_word(v);
        chk("R7", "no data after timeout", {16'd0, v}, 32'd0);

        // R7: limit 0 behaves as 1
        set_lim(8'd0);
        start_cmd(2'd3);
        strobe(1'b1); gap(); gap();
        chk("R7", "limit zero", {31'd0, rsp_tmo_o}, 32'd1);

        // R10: start clears flags
        start_cmd(2'd2);
        chk("R10", "flags cleared", {30'd0, cmd_done_o, rsp_tmo_o}, 32'd0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule